// File: doc/BRIEF.md
# Register-Programmed Single-Word Bus Mover

This block moves one 32-bit word between the peripheral's own local storage and a remote location on a 64-bit system bus. Software sets it up through a small bank of byte-writable registers on a 32-bit slave port: an operation code, a local word address, a remote bus address, a transfer length and a byte-lane mask. A dedicated key byte then launches the transfer. The key byte clears itself once taken, so every transfer needs a fresh launch write.

In a bus write, the engine first reads the local word. It then copies that word onto both 32-bit halves of the 64-bit data bus and holds one request until the remote side acknowledges. In a bus read, the engine requests the remote word, takes the half chosen by remote address bit 2, and writes it into local storage. Before any request is issued, the setup is checked. A bad operation code, a length other than one word, or a lane mask that does not fit the addressed half raises an error flag and no bus cycle is made. A status word reports busy, done and error.

Top module: `sbm_master`

## Requirements
- R1: Register layout by byte address, with byte lane i of the slave port at address offset i: operation code at 0x00 (byte 0); local address at 0x04 (32 bits); remote address at 0x08 (32 bits); length at 0x0C (bits 15:0); lane mask at 0x0E (bits 23:16); launch key at 0x0F (bits 31:24); status at 0x10. Status bit 0 is busy, bit 1 is done and bit 2 is error. Each of these reads back what was written, and only enabled byte lanes change.
- R2: Only the key value 0x0A written to the launch byte starts the engine. Any other value leaves busy, done and error at 0 and issues no bus request.
- R3: Operation code 0x40 is a bus write. The engine reads the local word at the local address (read data comes one cycle after loc_rd) and requests a write to the remote address. The lane mask goes out as m_be, and the word is driven on both halves of m_wdata. Mask bit b covers m_wdata bits 8b+7:8b.
- R4: Operation code 0x80 is a bus read. The engine requests the remote address and takes m_rdata[63:32] when remote address bit 2 is 0, or m_rdata[31:0] when it is 1. It writes that word to the local address through loc_wr.
- R5: Once m_req rises, m_req, m_addr, m_be and m_wdata stay unchanged until the cycle in which m_ack is sampled high.
- R6: Busy reads 1 from the launch until the transfer completes, then done reads 1. Done stays set until software writes status with bit 1 set. Error stays set until software writes status with bit 2 set. An accepted launch clears both flags.
- R7: While busy, writes to the registers at 0x00 through 0x0F are ignored.
- R8: The lane mask must be 0xF0 when remote address bit 2 is 0, and 0x0F when it is 1. Any other mask sets error and issues no bus request.
- R9: A length other than 4 sets error and issues no bus request.
- R10: An operation code other than 0x40 or 0x80 sets error when the key is written, and issues no bus request.
- R11: The launch byte reads 0x00 after the key has been accepted, and no further transfer starts until the key is written again.
- R12: After reset every register and status bit reads 0, and m_req, loc_rd and loc_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_wr | input | 1 | Slave register write strobe |
| s_addr | input | SAW | Slave byte address (word-aligned) |
| s_be | input | 4 | Slave write byte enables |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data for s_addr (combinational) |
| loc_addr | output | 32 | Local storage address |
| loc_rd | output | 1 | Local read strobe; data expected next cycle |
| loc_wr | output | 1 | Local write strobe |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data |
| m_req | output | 1 | Bus request, held until acknowledged |
| m_rnw | output | 1 | 1 for a bus read, 0 for a bus write |
| m_addr | output | 32 | Remote bus address |
| m_be | output | BW/8 | Bus byte-lane enables |
| m_wdata | output | BW | Bus write data |
| m_rdata | input | BW | Bus read data, valid with m_ack |
| m_ack | input | 1 | Bus acknowledge, a one-cycle pulse |

## Verification
The assertions assume three things about the surroundings. First, m_ack is a single-cycle pulse that only comes while m_req is high. Second, local read data arrives exactly one cycle after loc_rd. Third, software does not rewrite the setup registers in the cycle a launch is being taken. The bench models the remote slave and the local storage so that they behave this way. It pulses the acknowledge after a programmable wait and returns local data with a one-cycle latency. It also issues every register write only while the engine is idle, except for the deliberate writes made during a transfer to test R7.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   localparam int WORD_W = 32;
   localparam logic [7:0] GO_KEY   = 8'h0A;
   localparam logic [7:0] OP_WRITE = 8'h40;
   localparam logic [7:0] OP_READ  = 8'h80;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LRD,
      ST_LCAP,
      ST_BUS,
      ST_LWR
   } sbm_state_t;
endpackage

// File: rtl/sbm_regs.sv
module sbm_regs
   import sbm_pkg::*;
#(
   parameter int SAW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_wr,
   input  logic [SAW-1:0]    s_addr,
   input  logic [3:0]        s_be,
   input  logic [31:0]       s_wdata,
   output logic [31:0]       s_rdata,
   input  logic              busy,
   input  logic              go_taken,
   input  logic              set_done,
   input  logic              set_err,
   output logic [7:0]        op,
   output logic [31:0]       laddr,
   output logic [31:0]       raddr,
   output logic [15:0]       len,
   output logic [7:0]        be,
   output logic              go_ok
);
   localparam int WIW = SAW - 2;

   logic [WIW-1:0] widx;
   logic           cfg_wr;
   logic [7:0]     op_q, be_q, go_q;
   logic [31:0]    laddr_q, raddr_q;
   logic [15:0]    len_q;
   logic           done_q, err_q;
   logic           clr_done, clr_err;

   assign widx     = s_addr[SAW-1:2];
   assign cfg_wr   = s_wr && !busy;
   assign clr_done = s_wr && (widx == WIW'(4)) && s_be[0] && s_wdata[1];
   assign clr_err  = s_wr && (widx == WIW'(4)) && s_be[0] && s_wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= '0;
         laddr_q <= '0;
         raddr_q <= '0;
         len_q   <= '0;
         be_q    <= '0;
         go_q    <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (cfg_wr && widx == WIW'(0) && s_be[0]) op_q <= s_wdata[7:0];
         for (int i = 0; i < 4; i++) begin
            if (cfg_wr && widx == WIW'(1) && s_be[i]) laddr_q[8*i +: 8] <= s_wdata[8*i +: 8];
            if (cfg_wr && widx == WIW'(2) && s_be[i]) raddr_q[8*i +: 8] <= s_wdata[8*i +: 8];
         end
         if (cfg_wr && widx == WIW'(3)) begin
            if (s_be[0]) len_q[7:0]  <= s_wdata[7:0];
            if (s_be[1]) len_q[15:8] <= s_wdata[15:8];
            if (s_be[2]) be_q        <= s_wdata[23:16];
         end
         if (go_taken)
            go_q <= '0;
         else if (cfg_wr && widx == WIW'(3) && s_be[3])
            go_q <= s_wdata[31:24];
         if (go_taken) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end else begin
            if (clr_done) done_q <= 1'b0;
            if (clr_err)  err_q  <= 1'b0;
         end
         if (set_done) done_q <= 1'b1;
         if (set_err)  err_q  <= 1'b1;
      end
   end

   always_comb begin
      case (widx)
         WIW'(0): s_rdata = {24'h0, op_q};
         WIW'(1): s_rdata = laddr_q;
         WIW'(2): s_rdata = raddr_q;
         WIW'(3): s_rdata = {go_q, be_q, len_q};
         WIW'(4): s_rdata = {29'h0, err_q, done_q, busy};
         default: s_rdata = '0;
      endcase
   end

   assign op    = op_q;
   assign laddr = laddr_q;
   assign raddr = raddr_q;
   assign len   = len_q;
   assign be    = be_q;
   assign go_ok = (go_q == GO_KEY);

   // R7
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && s_wr && widx <= WIW'(3)) |=>
         ($stable(op_q) && $stable(laddr_q) && $stable(raddr_q) && $stable(len_q) && $stable(be_q)));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !go_taken && !clr_done) |=> done_q);

   // R11
   go_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_taken |=> (go_q == 8'h00));
endmodule

// File: rtl/sbm_chk.sv
module sbm_chk
   import sbm_pkg::*;
#(
   parameter int BW = 64
) (
   input  logic [7:0]                       op,
   input  logic [15:0]                      len,
   input  logic [7:0]                       be,
   input  logic [$clog2(BW/WORD_W)-1:0]     half_sel,
   output logic                             op_valid,
   output logic                             is_read,
   output logic                             be_ok,
   output logic                             len_ok
);
   localparam int BEW = BW / 8;
   localparam int LB  = WORD_W / 8;
   localparam logic [BEW-1:0] BE_TOP = {{LB{1'b1}}, {(BEW-LB){1'b0}}};

   logic [BEW-1:0] exp_be;

   always_comb begin
      exp_be   = BE_TOP >> (LB * int'(half_sel));
      is_read  = (op == OP_READ);
      op_valid = (op == OP_READ) || (op == OP_WRITE);
      len_ok   = (len == 16'(LB));
      be_ok    = (be == 8'(exp_be));
   end
endmodule

// File: rtl/sbm_fsm.sv
module sbm_fsm
   import sbm_pkg::*;
#(
   parameter int BW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_ok,
   input  logic              op_valid,
   input  logic              is_read,
   input  logic              be_ok,
   input  logic              len_ok,
   input  logic [31:0]       laddr,
   input  logic [31:0]       raddr,
   input  logic [7:0]        be,
   output logic              busy,
   output logic              go_taken,
   output logic              set_done,
   output logic              set_err,
   output logic [31:0]       loc_addr,
   output logic              loc_rd,
   output logic              loc_wr,
   output logic [31:0]       loc_wdata,
   input  logic [31:0]       loc_rdata,
   output logic              m_req,
   output logic              m_rnw,
   output logic [31:0]       m_addr,
   output logic [BW/8-1:0]   m_be,
   output logic [BW-1:0]     m_wdata,
   input  logic [BW-1:0]     m_rdata,
   input  logic              m_ack
);
   localparam int HALVES = BW / WORD_W;
   localparam int SELW   = $clog2(HALVES);
   localparam int BOFF   = $clog2(WORD_W / 8);

   sbm_state_t        st;
   logic              rnw_q;
   logic [WORD_W-1:0] word_q;
   logic [SELW-1:0]   half_sel;
   logic              launch_ok;
   logic [WORD_W-1:0] rd_half;

   assign half_sel  = raddr[BOFF +: SELW];
   assign launch_ok = op_valid && be_ok && len_ok;
   assign go_taken  = (st == ST_IDLE) && go_ok;
   assign set_err   = go_taken && !launch_ok;
   assign set_done  = (st == ST_BUS && m_ack && !rnw_q) || (st == ST_LWR);
   assign busy      = (st != ST_IDLE);
   assign rd_half   = m_rdata[(BW-1) - WORD_W*int'(half_sel) -: WORD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         rnw_q  <= 1'b0;
         word_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (go_taken && launch_ok) begin
               rnw_q <= is_read;
               st    <= is_read ? ST_BUS : ST_LRD;
            end
            ST_LRD:  st <= ST_LCAP;
            ST_LCAP: begin
               word_q <= loc_rdata;
               st     <= ST_BUS;
            end
            ST_BUS: if (m_ack) begin
               if (rnw_q) word_q <= rd_half;
               st <= rnw_q ? ST_LWR : ST_IDLE;
            end
            ST_LWR:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign loc_addr  = laddr;
   assign loc_rd    = (st == ST_LRD);
   assign loc_wr    = (st == ST_LWR);
   assign loc_wdata = word_q;
   assign m_req     = (st == ST_BUS);
   assign m_rnw     = rnw_q;
   assign m_addr    = raddr;
   assign m_be      = be[BW/8-1:0];

   for (genvar g = 0; g < HALVES; g++) begin : g_lane
      assign m_wdata[g*WORD_W +: WORD_W] = word_q;
   end

   // R2
   no_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !go_ok) |=> (st == ST_IDLE));

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_be) && $stable(m_wdata)));

   // R3
   wdata_from_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LCAP) |=> (m_wdata[WORD_W-1:0] == $past(loc_rdata)));

   // R8
   no_bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |-> (be_ok && len_ok && op_valid));
endmodule

// File: rtl/sbm_master.sv
module sbm_master
   import sbm_pkg::*;
#(
   parameter int BW  = 64,
   parameter int SAW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_wr,
   input  logic [SAW-1:0]    s_addr,
   input  logic [3:0]        s_be,
   input  logic [31:0]       s_wdata,
   output logic [31:0]       s_rdata,
   output logic [31:0]       loc_addr,
   output logic              loc_rd,
   output logic              loc_wr,
   output logic [31:0]       loc_wdata,
   input  logic [31:0]       loc_rdata,
   output logic              m_req,
   output logic              m_rnw,
   output logic [31:0]       m_addr,
   output logic [BW/8-1:0]   m_be,
   output logic [BW-1:0]     m_wdata,
   input  logic [BW-1:0]     m_rdata,
   input  logic              m_ack
);
   localparam int SELW = $clog2(BW / WORD_W);

   if (BW % WORD_W != 0 || BW / WORD_W < 2 || BW / 8 > 8) begin : g_bw_bad
      $error("sbm_master: BW must hold at least two 32-bit halves and at most 8 lanes");
   end
   if (SAW < 5) begin : g_saw_bad
      $error("sbm_master: SAW must cover the status word");
   end

   logic [7:0]  op, be;
   logic [31:0] laddr, raddr;
   logic [15:0] len;
   logic        go_ok, busy, go_taken, set_done, set_err;
   logic        op_valid, is_read, be_ok, len_ok;

   sbm_regs #(.SAW(SAW)) i_regs (
      .clk(clk), .rst_n(rst_n), .s_wr(s_wr), .s_addr(s_addr), .s_be(s_be),
      .s_wdata(s_wdata), .s_rdata(s_rdata), .busy(busy), .go_taken(go_taken),
      .set_done(set_done), .set_err(set_err), .op(op), .laddr(laddr),
      .raddr(raddr), .len(len), .be(be), .go_ok(go_ok)
   );

   sbm_chk #(.BW(BW)) i_chk (
      .op(op), .len(len), .be(be), .half_sel(raddr[2 +: SELW]),
      .op_valid(op_valid), .is_read(is_read), .be_ok(be_ok), .len_ok(len_ok)
   );

   sbm_fsm #(.BW(BW)) i_fsm (
      .clk(clk), .rst_n(rst_n), .go_ok(go_ok), .op_valid(op_valid),
      .is_read(is_read), .be_ok(be_ok), .len_ok(len_ok), .laddr(laddr),
      .raddr(raddr), .be(be), .busy(busy), .go_taken(go_taken),
      .set_done(set_done), .set_err(set_err), .loc_addr(loc_addr),
      .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
      .loc_rdata(loc_rdata), .m_req(m_req), .m_rnw(m_rnw), .m_addr(m_addr),
      .m_be(m_be), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
   );
endmodule

// File: tb/test_sbm_master.sv
`timescale 1ns/1ps
module test_sbm_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_wr = 1'b0;
   logic [4:0]  s_addr = '0;
   logic [3:0]  s_be = '0;
   logic [31:0] s_wdata = '0;
   logic [31:0] s_rdata;
   logic [31:0] loc_addr, loc_wdata;
   logic [31:0] loc_rdata = '0;
   logic        loc_rd, loc_wr;
   logic        m_req, m_rnw;
   logic [31:0] m_addr;
   logic [7:0]  m_be;
   logic [63:0] m_wdata, m_rdata;
   logic        m_ack = 1'b0;

   always #5 clk = ~clk;

   sbm_master i_sbm_master (
      .clk(clk), .rst_n(rst_n), .s_wr(s_wr), .s_addr(s_addr), .s_be(s_be),
      .s_wdata(s_wdata), .s_rdata(s_rdata), .loc_addr(loc_addr), .loc_rd(loc_rd),
      .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .m_req(m_req), .m_rnw(m_rnw), .m_addr(m_addr), .m_be(m_be),
      .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
   );

   // models of local storage and remote slave
   logic [31:0] lmem [16];
   logic [63:0] rmem [16];
   logic        pl_l = 1'b0, pl_r = 1'b0;
   logic [3:0]  pl_idx = '0;
   logic [31:0] pl_lval = '0;
   logic [63:0] pl_rval = '0;
   int          ack_wait = 2;
   int          ack_cnt = 0;
   int          comp_cnt = 0;
   logic [63:0] cap_wdata = '0;

   assign m_rdata = rmem[m_addr[6:3]];

   initial begin
      for (int i = 0; i < 16; i++) begin
         lmem[i] = '0;
         rmem[i] = '0;
      end
   end

   always @(posedge clk) begin
      if (pl_l) lmem[pl_idx] <= pl_lval;
      if (pl_r) rmem[pl_idx] <= pl_rval;
      if (loc_rd) loc_rdata <= lmem[loc_addr[5:2]];
      if (loc_wr) lmem[loc_addr[5:2]] <= loc_wdata;
      if (m_req && !m_ack) begin
         if (ack_cnt >= ack_wait) begin
            m_ack   <= 1'b1;
            ack_cnt <= 0;
         end else ack_cnt <= ack_cnt + 1;
      end else m_ack <= 1'b0;
      if (m_req && m_ack) begin
         comp_cnt  <= comp_cnt + 1;
         cap_wdata <= m_wdata;
         if (!m_rnw)
            for (int b = 0; b < 8; b++)
               if (m_be[b]) rmem[m_addr[6:3]][8*b +: 8] <= m_wdata[8*b +: 8];
      end
   end

   // hold monitor for R5
   int          mism_cnt = 0;
   logic        req_seen = 1'b0;
   logic [31:0] h_addr;
   logic [7:0]  h_be;
   logic [63:0] h_wdata;
   always @(negedge clk) begin
      if (m_req && req_seen)
         if (m_addr !== h_addr || m_be !== h_be || m_wdata !== h_wdata) mism_cnt++;
      if (m_req && !req_seen) begin
         h_addr = m_addr; h_be = m_be; h_wdata = m_wdata;
      end
      req_seen = m_req && !m_ack;
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic swrite(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      s_addr = a; s_be = b; s_wdata = d; s_wr = 1'b1;
      @(negedge clk);
      s_wr = 1'b0; s_be = '0;
   endtask

   task automatic sread(input logic [4:0] a, output logic [31:0] d);
      s_addr = a;
      #1;
      d = s_rdata;
   endtask

   task automatic preload(input bit is_loc, input logic [3:0] idx, input logic [63:0] val);
      @(negedge clk);
      pl_idx = idx; pl_lval = val[31:0]; pl_rval = val;
      if (is_loc) pl_l = 1'b1; else pl_r = 1'b1;
      @(negedge clk);
      pl_l = 1'b0; pl_r = 1'b0;
   endtask

   task automatic setup(input logic [7:0] op, input logic [31:0] la, input logic [31:0] ra,
                        input logic [15:0] ln, input logic [7:0] be);
      swrite(5'h00, 4'b0001, {24'h0, op});
      swrite(5'h04, 4'b1111, la);
      swrite(5'h08, 4'b1111, ra);
      swrite(5'h0C, 4'b0111, {8'h00, be, ln});
   endtask

   task automatic wait_idle();
      logic [31:0] st;
      repeat (2) @(negedge clk);
      for (int n = 0; n < 200; n++) begin
         sread(5'h10, st);
         if (!st[0]) break;
         @(negedge clk);
      end
   endtask

   typedef struct packed {
      logic [7:0]  op;
      logic [31:0] laddr;
      logic [31:0] raddr;
      logic [15:0] len;
      logic [7:0]  be;
      logic [31:0] val;
      logic        err;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{8'h40, 32'h08, 32'h10, 16'd4, 8'hF0, 32'hA1B2C3D4, 1'b0}, // R3 low address half
      '{8'h40, 32'h0C, 32'h24, 16'd4, 8'h0F, 32'h11223344, 1'b0}, // R3 high address half
      '{8'h80, 32'h10, 32'h30, 16'd4, 8'hF0, 32'hCAFEF00D, 1'b0}, // R4 upper bus half
      '{8'h80, 32'h14, 32'h3C, 16'd4, 8'h0F, 32'h0BADBEEF, 1'b0}, // R4 lower bus half
      '{8'h40, 32'h18, 32'h40, 16'd4, 8'h0F, 32'h55555555, 1'b1}, // R8 mask wrong half
      '{8'h80, 32'h1C, 32'h44, 16'd4, 8'hF0, 32'h66666666, 1'b1}, // R8 mask wrong half
      '{8'h40, 32'h20, 32'h50, 16'd8, 8'hF0, 32'h77777777, 1'b1}, // R9 bad length
      '{8'h20, 32'h24, 32'h58, 16'd4, 8'hF0, 32'h88888888, 1'b1}, // R10 bad code
      '{8'hC0, 32'h28, 32'h60, 16'd4, 8'hF0, 32'h99999999, 1'b1}  // R10 bad code
   };

   initial begin
      logic [31:0] rd;
      int c0;
      repeat (3) @(negedge clk);
      // R12 reset state
      for (int w = 0; w < 5; w++) begin
         sread(5'(w * 4), rd);
         chk(rd == 32'h0, "R12 register reads 0 after reset", 64'(rd), 64'h0);
      end
      chk(!m_req && !loc_rd && !loc_wr, "R12 strobes low in reset", {61'h0, m_req, loc_rd, loc_wr}, 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 byte-lane writes and readback
      swrite(5'h04, 4'b1111, 32'h12345678);
      swrite(5'h04, 4'b0100, 32'hFFAAFFFF);
      sread(5'h04, rd);
      chk(rd == 32'h12AA5678, "R1 byte-lane write to local address", 64'(rd), 64'h12AA5678);
      swrite(5'h0C, 4'b0111, 32'h00F00004);
      sread(5'h0C, rd);
      chk(rd == 32'h00F00004, "R1 length and mask fields", 64'(rd), 64'h00F00004);

      // R2 a non-key value does nothing
      setup(8'h40, 32'h08, 32'h10, 16'd4, 8'hF0);
      c0 = comp_cnt;
      swrite(5'h0C, 4'b1000, 32'h55000000);
      repeat (6) @(negedge clk);
      sread(5'h10, rd);
      chk(rd == 32'h0, "R2 status after non-key launch byte", 64'(rd), 64'h0);
      chk(comp_cnt == c0 && !m_req, "R2 no bus request", 64'(comp_cnt), 64'(c0));

      // vector table
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [3:0] ri, li;
         logic [63:0] exp_r;
         v = VECS[i];
         ri = v.raddr[6:3];
         li = v.laddr[5:2];
         if (v.op == 8'h80) begin
            preload(1'b0, ri, v.raddr[2] ? {32'h0, v.val} : {v.val, 32'h0});
            preload(1'b1, li, 64'h0);
         end else begin
            preload(1'b0, ri, 64'h0);
            preload(1'b1, li, {32'h0, v.val});
         end
         c0 = comp_cnt;
         setup(v.op, v.laddr, v.raddr, v.len, v.be);
         swrite(5'h0C, 4'b1000, 32'h0A000000);
         wait_idle();
         sread(5'h10, rd);
         chk(rd == (v.err ? 32'h4 : 32'h2), $sformatf("R6 status after vector %0d", i), 64'(rd), v.err ? 64'h4 : 64'h2);
         chk(comp_cnt == c0 + (v.err ? 0 : 1), $sformatf("R8 bus cycles for vector %0d", i), 64'(comp_cnt), 64'(c0 + (v.err ? 0 : 1)));
         if (v.op == 8'h80) begin
            chk(lmem[li] == (v.err ? 32'h0 : v.val), $sformatf("R4 local word vector %0d", i), 64'(lmem[li]), 64'(v.err ? 32'h0 : v.val));
         end else begin
            exp_r = v.err ? 64'h0 : (v.raddr[2] ? {32'h0, v.val} : {v.val, 32'h0});
            chk(rmem[ri] == exp_r, $sformatf("R3 remote word vector %0d", i), rmem[ri], exp_r);
         end
      end

      // R11 launch byte self-clears, no restart
      sread(5'h0C, rd);
      chk(rd[31:24] == 8'h00, "R11 launch byte reads 0", 64'(rd[31:24]), 64'h0);
      c0 = comp_cnt;
      setup(8'h40, 32'h08, 32'h10, 16'd4, 8'hF0);
      repeat (6) @(negedge clk);
      chk(comp_cnt == c0, "R11 no restart without fresh key", 64'(comp_cnt), 64'(c0));

      // R6 error clear (error left set by the last vector)
      sread(5'h10, rd);
      chk(rd == 32'h4, "R6 error still set", 64'(rd), 64'h4);
      swrite(5'h10, 4'b0001, 32'h4);
      sread(5'h10, rd);
      chk(rd == 32'h0, "R6 error cleared by status write", 64'(rd), 64'h0);

      // R7, R5: slow acknowledge with setup writes during busy
      ack_wait = 12;
      preload(1'b1, 4'd8, 64'h5EED1234);
      preload(1'b0, 4'd12, 64'h0);
      setup(8'h40, 32'h20, 32'h60, 16'd4, 8'hF0);
      swrite(5'h0C, 4'b1000, 32'h0A000000);
      for (int n = 0; n < 50; n++) begin
         if (m_req) break;
         @(negedge clk);
      end
      sread(5'h10, rd);
      chk(rd == 32'h1, "R6 busy during transfer", 64'(rd), 64'h1);
      swrite(5'h04, 4'b1111, 32'hFFFFFFFF);
      swrite(5'h08, 4'b1111, 32'h0);
      swrite(5'h00, 4'b0001, 32'h80);
      sread(5'h04, rd);
      chk(rd == 32'h20, "R7 local address kept while busy", 64'(rd), 64'h20);
      sread(5'h08, rd);
      chk(rd == 32'h60, "R7 remote address kept while busy", 64'(rd), 64'h60);
      sread(5'h00, rd);
      chk(rd == 32'h40, "R7 operation code kept while busy", 64'(rd), 64'h40);
      wait_idle();
      chk(rmem[12] == 64'h5EED1234_00000000, "R3 slow write result", rmem[12], 64'h5EED1234_00000000);
      chk(cap_wdata == 64'h5EED1234_5EED1234, "R3 word on both halves", cap_wdata, 64'h5EED1234_5EED1234);
      chk(mism_cnt == 0, "R5 request fields held until ack", 64'(mism_cnt), 64'h0);

      // R6 done sticky then cleared
      repeat (10) @(negedge clk);
      sread(5'h10, rd);
      chk(rd == 32'h2, "R6 done stays set", 64'(rd), 64'h2);
      swrite(5'h10, 4'b0001, 32'h2);
      sread(5'h10, rd);
      chk(rd == 32'h0, "R6 done cleared by status write", 64'(rd), 64'h0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule